// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the synchronous control logic for one leg of an H-bridge gate driver. It turns a low-side command, a high-side command, a global disable and two undervoltage flags into two gate-enable outputs, one for the low switch and one for the high switch. Two copies side by side control a full bridge.

Any request to switch a gate off takes effect on the next clock edge. A request to switch a gate on waits until the opposite gate has been low for a programmable number of cycles. This dead time, together with the priority of the low command, keeps both switches from conducting at once. If the high command is tied high, the low command alone drives both gates in complementary fashion (bistate use).

When the disable or the supply undervoltage condition is released, the low gate is first forced on for a fixed refresh window so that the high-side bootstrap capacitor can recharge. The high gate stays locked out for a longer hold-off. Reset behaves like a disable that has just been released.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While rst_ni is low, both outputs are 0. After reset is released, the block starts with a refresh window and a hold-off, exactly as after a disable release.
- R2: If disable_i or vdd_uv_i is 1 at a clock edge, both outputs are 0 after that edge, whatever the other inputs are.
- R3: A 1 on lo_cmd_i at a clock edge forces hi_gate_o to 0 after that edge, even when hi_cmd_i is 1.
- R4: hi_gate_o can only go to 1 after an edge where lo_cmd_i=0, hi_cmd_i=1, disable_i=0, vdd_uv_i=0 and boot_uv_i=0, and only once the hold-off has expired.
- R5: If boot_uv_i is 1 at an edge, hi_gate_o is 0 after that edge. The flag has no effect on lo_gate_o.
- R6: When a gate's request drops, the gate goes to 0 on the very next edge, with no dead time added.
- R7: A gate rises only after the opposite gate has been 0 for DEAD_CYC consecutive cycles. When the gate request arrives as the opposite gate falls, both gates are 0 for exactly DEAD_CYC cycles.
- R8: With hi_cmd_i held at 1, lo_cmd_i alone selects which gate is driven. Each hand-over has both gates low for DEAD_CYC cycles.
- R9: On the first edge where disable_i and vdd_uv_i are both 0 after either was set, or after reset, the low gate is requested for exactly REFRESH_CYC cycles, regardless of lo_cmd_i.
- R10: After the release edge, hi_gate_o stays 0 for at least HOLD_CYC cycles. HOLD_CYC must be greater than REFRESH_CYC.
- R11: lo_gate_o and hi_gate_o are never both 1.
- R12: A one-cycle command pulse is reproduced as a one-cycle output pulse when the opposite gate has already been low for the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_cmd_i | input | 1 | Low-side switch command |
| hi_cmd_i | input | 1 | High-side switch command; tie to 1 for bistate use |
| disable_i | input | 1 | Global disable, forces both gates off |
| vdd_uv_i | input | 1 | Supply undervoltage flag, forces both gates off |
| boot_uv_i | input | 1 | Bootstrap undervoltage flag, forces the high gate off |
| lo_gate_o | output | 1 | Low-side gate enable |
| hi_gate_o | output | 1 | High-side gate enable |

## Verification
The bench builds the block with DEAD_CYC=3, REFRESH_CYC=4 and HOLD_CYC=9. These small values let it measure a full refresh window, the gap between the refresh and the hold-off, and every dead-time gap to the exact cycle within a few clocks. They also mean that randomly toggled commands, disables and undervoltage flags often land inside a dead time or a hold-off that is still running. Single-cycle command pulses and disable pulses exercise the edges of the dead-time counters.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned SIDE_LO = 0;
  localparam int unsigned SIDE_HI = 1;
  localparam int unsigned N_SIDE  = 2;

  typedef logic [N_SIDE-1:0] side_vec_t;
endpackage

// File: rtl/hb_release_seq.sv
// Counts cycles since the last release of the blocking condition.
module hb_release_seq #(
  parameter int unsigned REFRESH_CYC = 32,
  parameter int unsigned HOLD_CYC    = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_i,
  output logic refresh_o,
  output logic hold_ok_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] REF_LIM  = CW'(REFRESH_CYC);
  localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (blk_i) begin
      cnt_q <= '0;
    end else if (cnt_q != HOLD_LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign refresh_o = ~blk_i & (cnt_q < REF_LIM);
  assign hold_ok_o = (cnt_q == HOLD_LIM);
endmodule

// File: rtl/hb_req_arb.sv
// Truth-table arbitration of gate requests.
module hb_req_arb
  import hb_pkg::*;
(
  input  logic      lo_cmd_i,
  input  logic      hi_cmd_i,
  input  logic      blk_i,
  input  logic      boot_uv_i,
  input  logic      refresh_i,
  input  logic      hold_ok_i,
  output side_vec_t req_o
);
  always_comb begin
    req_o = '0;
    if (blk_i) begin
      req_o = '0;
    end else if (refresh_i) begin
      req_o[SIDE_LO] = 1'b1;
    end else begin
      req_o[SIDE_LO] = lo_cmd_i;
      req_o[SIDE_HI] = hi_cmd_i & ~lo_cmd_i & ~boot_uv_i & hold_ok_i;
    end
  end
endmodule

// File: rtl/hb_gate_channel.sv
// One gate: immediate turn-off, turn-on gated by opposite-side idle time.
module hb_gate_channel #(
  parameter int unsigned DEAD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic opp_i,
  output logic gate_o
);
  localparam int unsigned GW = $clog2(DEAD_CYC + 1);
  localparam logic [GW-1:0] SAT = GW'(DEAD_CYC - 1);

  logic [GW-1:0] gap_q;
  logic          gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= SAT;
      gate_q <= 1'b0;
    end else begin
      if (opp_i)              gap_q <= '0;
      else if (gap_q != SAT)  gap_q <= gap_q + 1'b1;
      gate_q <= req_i & ~opp_i & (gate_q | (gap_q == SAT));
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC    = 16,
  parameter int unsigned REFRESH_CYC = 32,
  parameter int unsigned HOLD_CYC    = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_cmd_i,
  input  logic hi_cmd_i,
  input  logic disable_i,
  input  logic vdd_uv_i,
  input  logic boot_uv_i,
  output logic lo_gate_o,
  output logic hi_gate_o
);
  logic      blk;
  logic      refresh;
  logic      hold_ok;
  side_vec_t req;
  side_vec_t gate;

  assign blk = disable_i | vdd_uv_i;

  hb_release_seq #(
    .REFRESH_CYC(REFRESH_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_rel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blk_i    (blk),
    .refresh_o(refresh),
    .hold_ok_o(hold_ok)
  );

  hb_req_arb u_arb (
    .lo_cmd_i (lo_cmd_i),
    .hi_cmd_i (hi_cmd_i),
    .blk_i    (blk),
    .boot_uv_i(boot_uv_i),
    .refresh_i(refresh),
    .hold_ok_i(hold_ok),
    .req_o    (req)
  );

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    hb_gate_channel #(
      .DEAD_CYC(DEAD_CYC)
    ) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req[s]),
      .opp_i (gate[N_SIDE-1-s]),
      .gate_o(gate[s])
    );
  end

  assign lo_gate_o = gate[SIDE_LO];
  assign hi_gate_o = gate[SIDE_HI];
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int unsigned DEAD_CYC    = 16,
  parameter int unsigned REFRESH_CYC = 32,
  parameter int unsigned HOLD_CYC    = 128
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lo_cmd_i,
  input logic hi_cmd_i,
  input logic disable_i,
  input logic vdd_uv_i,
  input logic boot_uv_i,
  input logic lo_gate_o,
  input logic hi_gate_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [DW-1:0] lo_idle_q, hi_idle_q;
  logic [HW-1:0] since_rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_idle_q   <= DW'(DEAD_CYC);
      hi_idle_q   <= DW'(DEAD_CYC);
      since_rel_q <= '0;
    end else begin
      if (lo_gate_o) lo_idle_q <= '0;
      else if (lo_idle_q != DW'(DEAD_CYC)) lo_idle_q <= lo_idle_q + 1'b1;
      if (hi_gate_o) hi_idle_q <= '0;
      else if (hi_idle_q != DW'(DEAD_CYC)) hi_idle_q <= hi_idle_q + 1'b1;
      if (disable_i || vdd_uv_i) since_rel_q <= '0;
      else if (since_rel_q != HW'(HOLD_CYC)) since_rel_q <= since_rel_q + 1'b1;
    end
  end

  a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_gate_o && hi_gate_o));

  a_r2_block_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disable_i || vdd_uv_i) |=> (!lo_gate_o && !hi_gate_o));

  a_r3_lo_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cmd_i |=> !hi_gate_o);

  a_r5_boot_uv_hi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_uv_i |=> !hi_gate_o);

  a_r4_hi_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_gate_o) |-> $past(hi_cmd_i && !lo_cmd_i));

  a_r7_lo_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_gate_o) |-> (hi_idle_q >= DW'(DEAD_CYC)));

  a_r7_hi_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_gate_o) |-> (lo_idle_q >= DW'(DEAD_CYC)));

  a_r10_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_gate_o |-> (since_rel_q == HW'(HOLD_CYC)));
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
  .DEAD_CYC   (DEAD_CYC),
  .REFRESH_CYC(REFRESH_CYC),
  .HOLD_CYC   (HOLD_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lo_cmd_i (lo_cmd_i),
  .hi_cmd_i (hi_cmd_i),
  .disable_i(disable_i),
  .vdd_uv_i (vdd_uv_i),
  .boot_uv_i(boot_uv_i),
  .lo_gate_o(lo_gate_o),
  .hi_gate_o(hi_gate_o)
);

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb_top;
  localparam int DEAD = 3;
  localparam int REF  = 4;
  localparam int HOLD = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_cmd = 1'b0, hi_cmd = 1'b0, dis = 1'b1, vuv = 1'b0, buv = 1'b0;
  logic lo_g, hi_g;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_gate_ctrl #(
    .DEAD_CYC(DEAD), .REFRESH_CYC(REF), .HOLD_CYC(HOLD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lo_cmd_i(lo_cmd), .hi_cmd_i(hi_cmd),
    .disable_i(dis), .vdd_uv_i(vuv), .boot_uv_i(buv),
    .lo_gate_o(lo_g), .hi_gate_o(hi_g)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: tracks idle time of each gate and time since release.
  int  m_since = 0;
  int  m_lo_idle = DEAD, m_hi_idle = DEAD;
  bit  m_lo = 1'b0, m_hi = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_since = 0; m_lo_idle = DEAD; m_hi_idle = DEAD;
      m_lo = 1'b0; m_hi = 1'b0;
    end else begin
      bit want_lo, want_hi, nlo, nhi;
      want_lo = 1'b0; want_hi = 1'b0;
      if (dis || vuv) begin
        want_lo = 1'b0; want_hi = 1'b0;
      end else if (m_since < REF) begin
        want_lo = 1'b1;
      end else begin
        want_lo = lo_cmd;
        want_hi = hi_cmd && !lo_cmd && !buv && (m_since >= HOLD);
      end
      // a gate may rise once the other has idled DEAD cycles including this edge
      nlo = want_lo && !m_hi && (m_lo || m_hi_idle + 1 >= DEAD);
      nhi = want_hi && !m_lo && (m_hi || m_lo_idle + 1 >= DEAD);
      m_lo_idle = m_lo ? 0 : (m_lo_idle < DEAD ? m_lo_idle + 1 : DEAD);
      m_hi_idle = m_hi ? 0 : (m_hi_idle < DEAD ? m_hi_idle + 1 : DEAD);
      m_since = (dis || vuv) ? 0 : (m_since < HOLD ? m_since + 1 : HOLD);
      m_lo = nlo; m_hi = nhi;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(lo_g == m_lo, cur_req, "lo_gate vs model", lo_g, m_lo);
      chk(hi_g == m_hi, cur_req, "hi_gate vs model", hi_g, m_hi);
      chk(!(lo_g && hi_g), "R11", "gates overlap", 1, 0);
    end
  end

  task automatic drive(input bit l, input bit h, input bit d, input bit v, input bit b);
    lo_cmd = l; hi_cmd = h; dis = d; vuv = v; buv = b;
  endtask

  int cyc = 0;
  always @(posedge clk) cyc++;

  initial begin
    while (cyc < 100000 && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt, first;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(lo_g == 0 && hi_g == 0, "R1", "outputs during reset", {lo_g, hi_g}, 0);

    // R1/R9/R10: release reset straight into run, bistate
    drive(0, 1, 0, 0, 0);
    rst_n = 1'b1;
    cnt = 0; first = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (lo_g) cnt++;
      if (hi_g && first == 0) first = k;
    end
    chk(cnt == REF, "R9", "refresh length after reset", cnt, REF);
    chk(first == HOLD + 1, "R10", "first high cycle after release", first, HOLD + 1);

    // R8/R7: bistate hand-over high -> low
    cur_req = "R8";
    drive(1, 1, 0, 0, 0);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!lo_g && !hi_g) cnt++;
    end
    chk(cnt == DEAD, "R7", "gap high->low", cnt, DEAD);
    chk(lo_g == 1, "R8", "low gate after hand-over", lo_g, 1);

    // R6/R8: drop low command: low off next edge, high after dead time
    drive(0, 1, 0, 0, 0);
    @(negedge clk);
    chk(lo_g == 0, "R6", "immediate low turn-off", lo_g, 0);
    cnt = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!lo_g && !hi_g) cnt++;
    end
    chk(cnt == DEAD, "R8", "gap low->high", cnt, DEAD);
    chk(hi_g == 1, "R8", "high gate after hand-over", hi_g, 1);

    // R3: both commands high in independent use
    cur_req = "R3";
    drive(1, 1, 0, 0, 0);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (hi_g) cnt++;
    end
    chk(cnt == 0, "R3", "high gate with low command", cnt, 0);

    // R6: high off immediately when its command drops
    drive(0, 0, 0, 0, 0);
    repeat (6) @(negedge clk);
    drive(0, 1, 0, 0, 0);
    repeat (6) @(negedge clk);
    chk(hi_g == 1, "R4", "high on with all conditions met", hi_g, 1);
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(hi_g == 0, "R6", "immediate high turn-off", hi_g, 0);

    // R12: single-cycle low pulse
    cur_req = "R12";
    repeat (6) @(negedge clk);
    drive(1, 0, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    chk(lo_g == 1, "R12", "pulse start", lo_g, 1);
    @(negedge clk);
    chk(lo_g == 0, "R12", "pulse end", lo_g, 0);

    // R5: bootstrap undervoltage
    cur_req = "R5";
    repeat (4) @(negedge clk);
    drive(0, 1, 0, 0, 0);
    repeat (6) @(negedge clk);
    drive(0, 1, 0, 0, 1);
    @(negedge clk);
    chk(hi_g == 0, "R5", "high off on boot uv", hi_g, 0);
    drive(1, 1, 0, 0, 1);
    repeat (DEAD + 2) @(negedge clk);
    chk(lo_g == 1, "R5", "low unaffected by boot uv", lo_g, 1);
    drive(0, 1, 0, 0, 1);
    repeat (8) @(negedge clk);
    chk(hi_g == 0, "R5", "high held off by boot uv", hi_g, 0);
    drive(0, 1, 0, 0, 0);
    repeat (6) @(negedge clk);
    chk(hi_g == 1, "R4", "high returns after boot uv clears", hi_g, 1);

    // R2: disable with high on, then release -> refresh
    cur_req = "R2";
    drive(1, 1, 1, 0, 0);
    @(negedge clk);
    chk(lo_g == 0 && hi_g == 0, "R2", "disable forces off", {lo_g, hi_g}, 0);
    repeat (5) @(negedge clk);
    chk(lo_g == 0, "R2", "disable holds low off", lo_g, 0);
    cur_req = "R9";
    drive(0, 1, 0, 0, 0);
    cnt = 0; first = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (lo_g) cnt++;
      if (hi_g && first == 0) first = k;
    end
    chk(cnt == REF, "R9", "refresh length after disable", cnt, REF);
    chk(first == HOLD + 1, "R10", "hold-off after disable", first, HOLD + 1);

    // R2: supply undervoltage
    cur_req = "R2";
    drive(0, 1, 0, 1, 0);
    @(negedge clk);
    chk(lo_g == 0 && hi_g == 0, "R2", "vdd uv forces off", {lo_g, hi_g}, 0);
    drive(1, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    chk(lo_g == 0, "R2", "vdd uv holds low off", lo_g, 0);
    drive(0, 0, 0, 0, 0);
    repeat (15) @(negedge clk);

    // R11: random stress against the model
    cur_req = "R11";
    for (int k = 0; k < 4000; k++) begin
      drive($urandom_range(0, 1), ($urandom_range(0, 3) != 0),
            ($urandom_range(0, 40) == 0), ($urandom_range(0, 60) == 0),
            ($urandom_range(0, 20) == 0));
      @(negedge clk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule